// File: doc/BRIEF.md
# Receive Loss-of-Signal and Loss-of-Clock Alarm Monitor

This block watches the receive side of a 2.048 Mbit/s line receiver and raises two active-low alarms. The loss-of-signal alarm combines an analog detector flag from outside the block with a digital detector. The digital detector counts consecutive zeros in the recovered data and clears on the first mark. The loss-of-clock alarm counts fixed windows of a free-running reference clock. It fires after a run of windows in which the recovered clock shows no rising edge, and it releases after a shorter run of windows that each hold one.

The block also gates the recovered clock and data toward the terminal side. When shutdown is enabled and loss of signal is present, it parks both outputs at fixed levels. It also forces the clock alarm, so a free-running oscillator clock never reaches downstream logic. A polarity select gives the inverted logic mode: the clock and data outputs are inverted, and so are the parked levels. An active-low alarm-test input drives both alarms to their alarm state and leaves the data path alone. During local loopback the analog detector is ignored, and only the zero-run detector can raise loss of signal.

Top module: `rx_alarm_monitor`

## Requirements
- R1: `los_n` stays high after 32 consecutive zeros are sampled on rising `rec_clk` edges and goes low when the 33rd consecutive zero is sampled (default ZERO_LIMIT = 32).
- R2: The first `rec_data` = 1 sampled by `rec_clk` clears the digital detector on that same edge, so `los_n` returns high when no other loss source is present.
- R3: With `loop_local_n` = 1, `ana_los` = 1 drives `los_n` low, whatever the state of the zero-run detector.
- R4: With `loop_local_n` = 0, `ana_los` has no effect: `los_n` stays high while recovered data carries marks.
- R5: After `rec_clk` stops, `loc_n` stays high for at least 2 windows of WIN_CYCLES (4) reference cycles. It goes low by the end of the third full window with no edge. It changes only at a window boundary.
- R6: After `rec_clk` resumes, `loc_n` stays low for at least one further window. It returns high once two consecutive windows have each seen a rising edge.
- R7: With `shutdown_en` = 1, `mode_inv` = 0 and loss of signal present, `loc_n` = 0, `rx_clk_out` = 1 and `rx_data_out` = 0.
- R8: With `mode_inv` = 1, the parked levels are `rx_clk_out` = 0 and `rx_data_out` = 1. Outside shutdown, `rx_clk_out` = ~`rec_clk` and `rx_data_out` = ~`rec_data`.
- R9: `alarm_test_n` = 0 forces `los_n` = 0 and `loc_n` = 0, while `rx_data_out` keeps following `rec_data`.
- R10: Synchronous reset clears the zero-run count and the window state, leaving `los_n` = 1 and `loc_n` = 1 when `ana_los` = 0.
- R11: With `shutdown_en` = 0, loss of signal has no effect on the receive outputs: `rx_clk_out` = `rec_clk` and `rx_data_out` = `rec_data` in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock that times the clock-loss windows |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| rec_clk | input | 1 | Recovered receive clock |
| rec_data | input | 1 | Recovered receive data, sampled on rising `rec_clk` |
| ana_los | input | 1 | Analog detector loss flag, active high |
| loop_local_n | input | 1 | Local loopback select, active low; masks `ana_los` |
| shutdown_en | input | 1 | Enables output parking and forced clock alarm on loss of signal |
| alarm_test_n | input | 1 | Alarm test, active low; forces both alarms |
| mode_inv | input | 1 | Inverted logic mode for receive clock and data |
| los_n | output | 1 | Loss-of-signal alarm, active low |
| loc_n | output | 1 | Loss-of-clock alarm, active low |
| rx_clk_out | output | 1 | Gated receive clock toward the terminal side |
| rx_data_out | output | 1 | Gated receive data toward the terminal side |

## Verification
The zero-run detector is driven with a run of exactly 32 zeros and then one more. This separates a greater-than threshold from a greater-or-equal one. A single mark then shows the clear happens on the sampling edge and not after a delay. The clock monitor is driven by stopping and restarting the recovered clock. The outputs are sampled at the earliest and latest legal window counts, which separates the three-window assert from the two-window release and catches an off-by-one window. Static settings of analog loss, loopback, shutdown, polarity and alarm test show which source drives each output and that loopback masks only the analog path.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int unsigned DEF_ZERO_LIMIT  = 32;
    localparam int unsigned DEF_WIN_CYCLES  = 4;
    localparam int unsigned DEF_QUIET_WINS  = 3;
    localparam int unsigned DEF_LIVE_WINS   = 2;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Outcome of one reference-clock window
    typedef enum logic [1:0] {
        WIN_OPEN  = 2'd0,
        WIN_QUIET = 2'd1,
        WIN_LIVE  = 2'd2
    } win_verdict_e;

    // Receive clock/data pair toward the terminal side
    typedef struct packed {
        logic clk;
        logic data;
    } rx_pair_t;

    // Levels parked on the outputs during shutdown
    function automatic rx_pair_t park_levels(input logic inv);
        rx_pair_t p;
        p.clk  = ~inv;
        p.data = inv;
        return p;
    endfunction

    // Normal pass-through with optional polarity inversion
    function automatic rx_pair_t pass_levels(input logic clk, input logic data,
                                             input logic inv);
        rx_pair_t p;
        p.clk  = clk ^ inv;
        p.data = data ^ inv;
        return p;
    endfunction

endpackage

// File: rtl/zero_run_det.sv
module zero_run_det #(
    parameter int unsigned ZERO_LIMIT = lsm_pkg::DEF_ZERO_LIMIT
) (
    input  logic rec_clk,
    input  logic rst,
    input  logic rec_data,
    output logic dig_loss
);
    localparam int unsigned RUN_W = $clog2(ZERO_LIMIT + 2);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(ZERO_LIMIT + 1);

    logic [RUN_W-1:0] run_q;

    // Counts zeros, clears on a mark, saturates one above the limit
    always_ff @(posedge rec_clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (rec_data) begin
            run_q <= '0;
        end else if (run_q != RUN_TOP) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign dig_loss = (run_q == RUN_TOP);

endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int unsigned STAGES = lsm_pkg::DEF_SYNC_STAGES
) (
    input  logic rec_clk,
    input  logic clk_ref,
    input  logic rst,
    output logic edge_seen
);
    logic              tog_q;
    logic [STAGES:0]   pipe_q;

    // One level change per recovered rising edge
    always_ff @(posedge rec_clk) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= ~tog_q;
    end

    // Synchronizer plus one history stage in the reference domain
    always_ff @(posedge clk_ref) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], tog_q};
    end

    assign edge_seen = pipe_q[STAGES] ^ pipe_q[STAGES-1];

endmodule

// File: rtl/loc_timer.sv
module loc_timer
    import lsm_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = DEF_WIN_CYCLES,
    parameter int unsigned QUIET_WINS = DEF_QUIET_WINS,
    parameter int unsigned LIVE_WINS  = DEF_LIVE_WINS
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic edge_seen,
    output logic loc_alarm,
    output logic win_end
);
    localparam int unsigned WW = $clog2(WIN_CYCLES);
    localparam int unsigned QW = $clog2(QUIET_WINS + 1);
    localparam int unsigned LW = $clog2(LIVE_WINS + 1);
    localparam logic [WW-1:0] WIN_LAST   = WW'(WIN_CYCLES - 1);
    localparam logic [QW-1:0] QUIET_TOP  = QW'(QUIET_WINS);
    localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_WINS - 1);
    localparam logic [LW-1:0] LIVE_TOP   = LW'(LIVE_WINS);
    localparam logic [LW-1:0] LIVE_LAST  = LW'(LIVE_WINS - 1);

    logic [WW-1:0] wcnt_q;
    logic          hit_q;
    logic          hit_any;
    logic [QW-1:0] quiet_q;
    logic [LW-1:0] live_q;
    win_verdict_e  verdict;

    assign win_end = (wcnt_q == WIN_LAST);
    assign hit_any = hit_q | edge_seen;

    always_comb begin
        if (!win_end)     verdict = WIN_OPEN;
        else if (hit_any) verdict = WIN_LIVE;
        else              verdict = WIN_QUIET;
    end

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            wcnt_q    <= '0;
            hit_q     <= 1'b0;
            quiet_q   <= '0;
            live_q    <= '0;
            loc_alarm <= 1'b0;
        end else begin
            wcnt_q <= win_end ? '0 : wcnt_q + 1'b1;
            hit_q  <= win_end ? 1'b0 : hit_any;
            case (verdict)
                WIN_QUIET: begin
                    live_q <= '0;
                    if (quiet_q != QUIET_TOP) quiet_q <= quiet_q + 1'b1;
                    if (quiet_q == QUIET_LAST) loc_alarm <= 1'b1;
                end
                WIN_LIVE: begin
                    quiet_q <= '0;
                    if (live_q != LIVE_TOP) live_q <= live_q + 1'b1;
                    if (live_q == LIVE_LAST) loc_alarm <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rx_alarm_monitor.sv
module rx_alarm_monitor
    import lsm_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT  = DEF_ZERO_LIMIT,
    parameter int unsigned WIN_CYCLES  = DEF_WIN_CYCLES,
    parameter int unsigned QUIET_WINS  = DEF_QUIET_WINS,
    parameter int unsigned LIVE_WINS   = DEF_LIVE_WINS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic rec_clk,
    input  logic rec_data,
    input  logic ana_los,
    input  logic loop_local_n,
    input  logic shutdown_en,
    input  logic alarm_test_n,
    input  logic mode_inv,
    output logic los_n,
    output logic loc_n,
    output logic rx_clk_out,
    output logic rx_data_out
);
    logic     dig_loss;
    logic     edge_seen;
    logic     loc_alarm;
    logic     win_end;
    logic     ana_used;
    logic     los_any;
    logic     park;
    logic     test_on;
    rx_pair_t rx_pair;

    zero_run_det #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
        .rec_clk  (rec_clk),
        .rst      (rst),
        .rec_data (rec_data),
        .dig_loss (dig_loss)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .rec_clk   (rec_clk),
        .clk_ref   (clk_ref),
        .rst       (rst),
        .edge_seen (edge_seen)
    );

    loc_timer #(
        .WIN_CYCLES (WIN_CYCLES),
        .QUIET_WINS (QUIET_WINS),
        .LIVE_WINS  (LIVE_WINS)
    ) u_loc (
        .clk_ref   (clk_ref),
        .rst       (rst),
        .edge_seen (edge_seen),
        .loc_alarm (loc_alarm),
        .win_end   (win_end)
    );

    // Analog flag only counts outside local loopback
    assign ana_used = ana_los & loop_local_n;
    assign los_any  = dig_loss | ana_used;
    assign park     = shutdown_en & los_any;
    assign test_on  = ~alarm_test_n;

    assign los_n = ~(los_any | test_on);
    assign loc_n = ~(loc_alarm | park | test_on);

    always_comb begin
        if (park) rx_pair = park_levels(mode_inv);
        else      rx_pair = pass_levels(rec_clk, rec_data, mode_inv);
    end

    assign rx_clk_out  = rx_pair.clk;
    assign rx_data_out = rx_pair.data;

endmodule

// File: rtl/lsm_checker.sv
module lsm_checker (
    input logic clk_ref,
    input logic rec_clk,
    input logic rst,
    input logic rec_data,
    input logic loop_local_n,
    input logic shutdown_en,
    input logic alarm_test_n,
    input logic mode_inv,
    input logic los_n,
    input logic loc_n,
    input logic rx_clk_out,
    input logic rx_data_out,
    input logic dig_loss,
    input logic edge_seen,
    input logic loc_alarm,
    input logic win_end
);

    assert_zero_before_loss_R1: assert property (
        @(posedge rec_clk) disable iff (rst)
        dig_loss |-> !$past(rec_data));

    assert_mark_clears_R2: assert property (
        @(posedge rec_clk) disable iff (rst)
        rec_data |=> !dig_loss);

    assert_loop_masks_analog_R4: assert property (
        @(posedge clk_ref) disable iff (rst)
        (!loop_local_n && !dig_loss && alarm_test_n) |-> los_n);

    assert_loc_on_boundary_R5: assert property (
        @(posedge clk_ref) disable iff (rst)
        (loc_alarm != $past(loc_alarm)) |-> $past(win_end));

    assert_loc_rise_quiet_R5: assert property (
        @(posedge clk_ref) disable iff (rst)
        $rose(loc_alarm) |-> !$past(edge_seen));

    // Covers the mode-dependent parked levels of R8 as well
    assert_park_levels_R7: assert property (
        @(posedge clk_ref) disable iff (rst)
        (shutdown_en && !los_n && alarm_test_n) |->
            (rx_clk_out == !mode_inv && rx_data_out == mode_inv && !loc_n));

    assert_test_forces_R9: assert property (
        @(posedge clk_ref) disable iff (rst)
        !alarm_test_n |-> (!los_n && !loc_n));

endmodule

bind rx_alarm_monitor lsm_checker u_chk (
    .clk_ref      (clk_ref),
    .rec_clk      (rec_clk),
    .rst          (rst),
    .rec_data     (rec_data),
    .loop_local_n (loop_local_n),
    .shutdown_en  (shutdown_en),
    .alarm_test_n (alarm_test_n),
    .mode_inv     (mode_inv),
    .los_n        (los_n),
    .loc_n        (loc_n),
    .rx_clk_out   (rx_clk_out),
    .rx_data_out  (rx_data_out),
    .dig_loss     (dig_loss),
    .edge_seen    (edge_seen),
    .loc_alarm    (loc_alarm),
    .win_end      (win_end)
);

// File: tb/sim_rx_alarm_monitor.sv
module sim_rx_alarm_monitor;

    localparam int WIN = 4;

    logic clk_ref = 1'b0;
    logic rst = 1'b1;
    logic rec_clk = 1'b0;
    logic rc_run = 1'b1;
    logic rec_data = 1'b1;
    logic ana_los = 1'b0;
    logic loop_local_n = 1'b1;
    logic shutdown_en = 1'b0;
    logic alarm_test_n = 1'b1;
    logic mode_inv = 1'b0;
    logic los_n, loc_n, rx_clk_out, rx_data_out;

    int checks = 0;
    int errors = 0;

    rx_alarm_monitor u0 (
        .clk_ref      (clk_ref),
        .rst          (rst),
        .rec_clk      (rec_clk),
        .rec_data     (rec_data),
        .ana_los      (ana_los),
        .loop_local_n (loop_local_n),
        .shutdown_en  (shutdown_en),
        .alarm_test_n (alarm_test_n),
        .mode_inv     (mode_inv),
        .los_n        (los_n),
        .loc_n        (loc_n),
        .rx_clk_out   (rx_clk_out),
        .rx_data_out  (rx_data_out)
    );

    always #10 clk_ref = ~clk_ref;
    always #15 rec_clk = rc_run ? ~rec_clk : 1'b0;

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge rec_clk) rec_data = b;
        @(posedge rec_clk);
    endtask

    task automatic t_reset;
        repeat (6) @(posedge clk_ref);
        #5 rst = 1'b0;
        @(posedge clk_ref); #5;
        check("R10", "los_n after reset", los_n, 1'b1);
        check("R10", "loc_n after reset", loc_n, 1'b1);
    endtask

    task automatic t_zero_run;
        send_bit(1'b1);
        repeat (32) send_bit(1'b0);
        #1 check("R1", "los_n after 32 zeros", los_n, 1'b1);
        send_bit(1'b0);
        #1 check("R1", "los_n after 33 zeros", los_n, 1'b0);
        check("R11", "rx_data_out pass during loss", rx_data_out, rec_data);
        check("R11", "rx_clk_out pass during loss", rx_clk_out, rec_clk);
    endtask

    task automatic t_shutdown;
        shutdown_en = 1'b1;
        #1;
        check("R7", "loc_n forced", loc_n, 1'b0);
        check("R7", "rx_clk_out parked", rx_clk_out, 1'b1);
        check("R7", "rx_data_out parked", rx_data_out, 1'b0);
        mode_inv = 1'b1;
        #1;
        check("R8", "rx_clk_out parked inv", rx_clk_out, 1'b0);
        check("R8", "rx_data_out parked inv", rx_data_out, 1'b1);
        send_bit(1'b1);
        #1 check("R2", "los_n after first mark", los_n, 1'b1);
        check("R8", "rx_clk_out inverted pass", rx_clk_out, 1'b0);
        check("R8", "rx_data_out inverted pass", rx_data_out, 1'b0);
        check("R2", "loc_n released with los", loc_n, 1'b1);
        shutdown_en = 1'b0;
        mode_inv = 1'b0;
    endtask

    task automatic t_analog;
        ana_los = 1'b1;
        @(posedge clk_ref); #5;
        check("R3", "los_n from analog", los_n, 1'b0);
        check("R11", "rx_data_out unaffected", rx_data_out, rec_data);
        loop_local_n = 1'b0;
        #2 check("R4", "analog masked in loopback", los_n, 1'b1);
        loop_local_n = 1'b1;
        ana_los = 1'b0;
        #2 check("R3", "los_n clear", los_n, 1'b1);
    endtask

    task automatic t_alarm_test;
        alarm_test_n = 1'b0;
        @(posedge clk_ref); #5;
        check("R9", "los_n forced by test", los_n, 1'b0);
        check("R9", "loc_n forced by test", loc_n, 1'b0);
        rec_data = 1'b0;
        #1 check("R9", "data follows 0", rx_data_out, 1'b0);
        rec_data = 1'b1;
        #1 check("R9", "data follows 1", rx_data_out, 1'b1);
        alarm_test_n = 1'b1;
        #2 check("R9", "alarms released", los_n & loc_n, 1'b1);
    endtask

    task automatic t_clock_loss;
        rec_data = 1'b1;
        @(posedge clk_ref); #5;
        rc_run = 1'b0;
        repeat (2 * WIN) @(posedge clk_ref);
        #5 check("R5", "loc_n held after 2 windows", loc_n, 1'b1);
        repeat (2 * WIN + 8) @(posedge clk_ref);
        #5 check("R5", "loc_n low after quiet windows", loc_n, 1'b0);
        check("R5", "los_n unaffected by clock stop", los_n, 1'b1);
        rc_run = 1'b1;
        repeat (WIN) @(posedge clk_ref);
        #5 check("R6", "loc_n held one window after restart", loc_n, 1'b0);
        repeat (2 * WIN + 8) @(posedge clk_ref);
        #5 check("R6", "loc_n released", loc_n, 1'b1);
    endtask

    initial begin
        t_reset();
        t_zero_run();
        t_shutdown();
        t_analog();
        t_alarm_test();
        t_clock_loss();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog run did not complete");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule